// File: doc/BRIEF.md
# Status Register and Write-Protection Controller

This block holds the status register of a serial non-volatile memory and rules on every command that the serial front end has decoded. When a command ends, the front end presents it as a single-cycle event. The event carries an operation code, the 19-bit target address, the last data byte and a flag. The flag says whether chip select rose exactly on a byte boundary. One cycle later the block answers with accept or reject. For an accepted array-programming command it also raises a start pulse towards the array programmer.

The protection decision has four inputs:
- Two block-protect bits, which select an upper fraction of the address space as read-only.
- A status-register-lock bit. Together with a low level on the active-low write-protect pin, it freezes the non-volatile bits.
- A write-enable latch, which clears itself after every write cycle.
- A self-timed busy interval. During it the status register stays readable, but most commands are refused, and new non-volatile values take effect only when it ends.

The busy interval is counted in system clocks through a parameter, so a short value can be used in simulation.

Top module: `swp_status_ctrl`

## Requirements
- R1: With block-protect bits (status b3:b2) 01, a WRITE to 60000h..7FFFFh is rejected. With 10, a WRITE to 40000h..7FFFFh is rejected. With 11, every WRITE address is rejected. With 00, no address is protected.
- R2: WEL (status b1) is set only by an accepted WREN. It is cleared by an accepted WRDI, at the end of every busy interval, and by reset. A rejected command leaves it unchanged.
- R3: Accepted write-type commands are WRSR, WRITE, ID write and lock. After one of them, WIP (status b0) is 1 from the next clock edge for exactly BUSY_CYCLES cycles, then returns to 0.
- R4: When the lock bit (status b7) is 1 and wp_n is 0, WRSR is rejected and the register keeps its contents. With wp_n at 1, WRSR is accepted again.
- R5: An accepted WRSR takes data bits 7, 3 and 2 into the lock bit, BP1 and BP0. All other data bits are ignored, and status b6..b4 always read 0.
- R6: New lock/BP values stay invisible while WIP is 1. They appear on the same edge that clears WIP.
- R7: WRITE, ID write and lock are rejected when WEL is 0 or when cmd_aligned is 0. Lock is also rejected when BP is 11.
- R8: While WIP is 1 every command, including READ, WREN and WRDI, is rejected. Otherwise READ, WREN and WRDI are accepted. Operation code 7 is always rejected.
- R9: Reset clears WEL, WIP and the response outputs, and keeps the lock and BP bits. Before the first WRSR these bits are 0.
- R10: resp_valid pulses one cycle after cmd_valid, and resp_accept carries the decision. prog_start pulses with the acceptance of WRITE, ID write or lock, and never for WRSR.
- R11: Operation codes: 0 WREN, 1 WRDI, 2 WRSR, 3 WRITE, 4 READ, 5 ID write, 6 lock, 7 unused. Status layout: b7 lock, b3 BP1, b2 BP0, b1 WEL, b0 WIP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Single-cycle strobe: a decoded command has terminated |
| cmd_op | input | 3 | Operation code of the command |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Last data byte shifted in |
| cmd_aligned | input | 1 | Chip select rose on a byte boundary |
| wp_n | input | 1 | Write-protect pin level, active low |
| status_byte | output | 8 | Status register image for a status read |
| wip | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| resp_valid | output | 1 | Decision strobe |
| resp_accept | output | 1 | Decision: 1 accepted, 0 rejected |
| prog_start | output | 1 | Start pulse to the array programmer |

## Verification
The assertions assume the following about the inputs:
- cmd_valid is a one-cycle pulse.
- cmd_op, cmd_addr, cmd_data and cmd_aligned are valid in that cycle.
- wp_n does not change in the cycle of a WRSR.
- Reset is held for at least one full clock.

The bench keeps to these assumptions. It drives every input on the falling edge and holds each command for one cycle, so no two events overlap. It changes wp_n only between commands and asserts reset only between commands, for two cycles.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    OP_WREN   = 3'd0,
    OP_WRDI   = 3'd1,
    OP_WRSR   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_IDWR   = 3'd5,
    OP_IDLOCK = 3'd6,
    OP_NONE   = 3'd7
  } cmd_op_e;

  // status byte bit positions
  localparam int SB_WIP  = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BP0  = 2;
  localparam int SB_BP1  = 3;
  localparam int SB_SRWD = 7;

  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
  } nv_bits_t;

  // commands that occupy a self-timed busy interval
  function automatic logic is_write_type(cmd_op_e op);
    return (op == OP_WRSR) || (op == OP_WRITE) || (op == OP_IDWR) || (op == OP_IDLOCK);
  endfunction

  // commands handed to the array programmer
  function automatic logic is_array_prog(cmd_op_e op);
    return (op == OP_WRITE) || (op == OP_IDWR) || (op == OP_IDLOCK);
  endfunction

endpackage

// File: rtl/swp_range_chk.sv
module swp_range_chk (
  input  logic [1:0] bp,
  input  logic [1:0] addr_top,
  output logic       hit
);
  // protected fraction grows from the top of the address space
  always_comb begin
    unique case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr_top;
      2'b10:   hit = addr_top[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/swp_busy_timer.sv
module swp_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/swp_nv_regs.sv
module swp_nv_regs
  import swp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  nv_bits_t load_val,
  input  logic     commit,
  output nv_bits_t nv
);
  // non-volatile image: not touched by reset, delivery value zero
  nv_bits_t nv_q = '0;
  nv_bits_t pend_q;
  logic     pend_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (load) begin
      pend_vld_q <= 1'b1;
      pend_q     <= load_val;
    end else if (commit) begin
      pend_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && commit && pend_vld_q) nv_q <= pend_q;
  end

  assign nv = nv_q;
endmodule

// File: rtl/swp_status_ctrl.sv
module swp_status_ctrl
  import swp_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_aligned,
  input  logic              wp_n,
  output logic [7:0]        status_byte,
  output logic              wip,
  output logic              wel,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic              prog_start
);
  localparam int TOP_LO = ADDR_W - 2;

  cmd_op_e  op;
  nv_bits_t nv;
  nv_bits_t wr_val;
  logic     busy, done, hit, hpm, write_ok, acc;
  logic     wel_q, rv_q, ra_q, ps_q;
  logic     start_cycle, load_nv;
  logic     unused_bits;

  assign op     = cmd_op_e'(cmd_op);
  assign wr_val = {cmd_data[SB_SRWD], cmd_data[SB_BP1], cmd_data[SB_BP0]};
  assign unused_bits = ^{cmd_data[6:4], cmd_data[1:0], cmd_addr[TOP_LO-1:0]};

  swp_range_chk u_range (
    .bp       (nv.bp),
    .addr_top (cmd_addr[ADDR_W-1:TOP_LO]),
    .hit      (hit)
  );

  swp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_cycle),
    .busy  (busy),
    .done  (done)
  );

  swp_nv_regs u_nv (
    .clk      (clk),
    .rst      (rst),
    .load     (load_nv),
    .load_val (wr_val),
    .commit   (done),
    .nv       (nv)
  );

  // decision logic
  always_comb begin
    hpm      = nv.srwd & ~wp_n;
    write_ok = wel_q & ~busy & cmd_aligned;
    unique case (op)
      OP_WREN, OP_WRDI, OP_READ: acc = ~busy;
      OP_WRSR:   acc = write_ok & ~hpm;
      OP_WRITE:  acc = write_ok & ~hit;
      OP_IDWR:   acc = write_ok;
      OP_IDLOCK: acc = write_ok & (nv.bp != 2'b11);
      default:   acc = 1'b0;
    endcase
  end

  assign start_cycle = cmd_valid & acc & is_write_type(op);
  assign load_nv     = cmd_valid & acc & (op == OP_WRSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
      rv_q  <= 1'b0;
      ra_q  <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      rv_q <= cmd_valid;
      ra_q <= cmd_valid & acc;
      ps_q <= cmd_valid & acc & is_array_prog(op);
      if (done)
        wel_q <= 1'b0;
      else if (cmd_valid && acc && op == OP_WREN)
        wel_q <= 1'b1;
      else if (cmd_valid && acc && op == OP_WRDI)
        wel_q <= 1'b0;
    end
  end

  always_comb begin
    status_byte          = '0;
    status_byte[SB_SRWD] = nv.srwd;
    status_byte[SB_BP1]  = nv.bp[1];
    status_byte[SB_BP0]  = nv.bp[0];
    status_byte[SB_WEL]  = wel_q;
    status_byte[SB_WIP]  = busy;
  end

  assign wip         = busy;
  assign wel         = wel_q;
  assign resp_valid  = rv_q;
  assign resp_accept = ra_q;
  assign prog_start  = ps_q;
endmodule

// File: rtl/swp_checker.sv
module swp_checker
  import swp_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wp_n,
  input logic [7:0] status_byte,
  input logic       wip,
  input logic       wel,
  input logic       resp_valid,
  input logic       resp_accept,
  input logic       prog_start
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst)      busy_len <= 0;
    else if (wip) busy_len <= busy_len + 1;
    else          busy_len <= 0;
  end

  // R1: full protection rejects every WRITE
  a_r1_full_protect: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && status_byte[3:2] == 2'b11) |=> !resp_accept);

  // R2: WEL only rises after a WREN
  a_r2_wel_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> ($past(cmd_valid) && $past(cmd_op) == OP_WREN));

  // R2: end of busy clears WEL
  a_r2_wel_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);

  // R3: busy interval length
  a_r3_busy_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(wip) && !$past(rst)) |-> (busy_len == BUSY_CYCLES));

  // R4: hardware-protected mode rejects WRSR
  a_r4_hpm_reject: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRSR && status_byte[7] && !wp_n) |=> (resp_valid && !resp_accept));

  // R5: unused status bits stay zero
  a_r5_zero_bits: assert property (@(posedge clk) disable iff (rst)
    status_byte[6:4] == 3'b000);

  // R6: non-volatile bits change only when busy ends
  a_r6_nv_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_byte[7:2]) |-> $fell(wip));

  // R8: nothing accepted while busy
  a_r8_busy_reject: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && wip) |=> !resp_accept);

  // R10: programmer start only with an acceptance
  a_r10_prog_accept: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> (resp_valid && resp_accept));
endmodule

bind swp_status_ctrl swp_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .wp_n        (wp_n),
  .status_byte (status_byte),
  .wip         (wip),
  .wel         (wel),
  .resp_valid  (resp_valid),
  .resp_accept (resp_accept),
  .prog_start  (prog_start)
);

// File: tb/swp_status_ctrl_tb.sv
`timescale 1ns/1ps
module swp_status_ctrl_tb;
  import swp_pkg::*;

  localparam int ADDR_W = 19;
  localparam int BUSY   = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0]        cmd_data = '0;
  logic              cmd_aligned = 1'b1;
  logic              wp_n = 1'b1;
  logic [7:0]        status_byte;
  logic              wip, wel, resp_valid, resp_accept, prog_start;

  swp_status_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_aligned(cmd_aligned),
    .wp_n(wp_n), .status_byte(status_byte), .wip(wip), .wel(wel),
    .resp_valid(resp_valid), .resp_accept(resp_accept), .prog_start(prog_start)
  );

  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  typedef struct { logic acc; logic prog; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input cmd_op_e op, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input logic al, input logic acc, input logic prog, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_aligned = al;
    sb_q.push_back('{acc, prog, tag});
    @(negedge clk);
    cmd_valid = 1'b0; cmd_aligned = 1'b1;
  endtask

  task automatic wait_idle();
    repeat (BUSY + 1) @(negedge clk);
  endtask

  // monitor: compare each decision against the scoreboard
  always @(negedge clk) begin
    if (resp_valid) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: actual unexpected response expected none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({7'd0, resp_accept}, {7'd0, e.acc}, {e.tag, " accept"});
        chk({7'd0, prog_start}, {7'd0, e.prog}, {e.tag, " prog_start"});
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status_byte, 8'h00, "R9 delivery state");
    chk({6'd0, wip, wel}, 8'h00, "R9 flags after reset");

    issue(OP_WRITE, 19'h00100, 8'hA5, 1'b1, 1'b0, 1'b0, "R7 write without WEL");
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R8 WREN idle");
    chk(status_byte, 8'h02, "R2 WEL set / R11 layout");
    issue(OP_WRDI, '0, '0, 1'b1, 1'b1, 1'b0, "R8 WRDI idle");
    chk(status_byte, 8'h00, "R2 WRDI clears WEL");

    // WRSR with busy-window detail
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRSR, '0, 8'hFF, 1'b1, 1'b1, 1'b0, "R10 WRSR accept no prog");
    chk(status_byte, 8'h03, "R3 WIP rises, R6 old bits");
    issue(OP_READ, '0, '0, 1'b1, 1'b0, 1'b0, "R8 READ while busy");
    issue(OP_WREN, '0, '0, 1'b1, 1'b0, 1'b0, "R8 WREN while busy");
    repeat (BUSY - 5) @(negedge clk);
    chk(status_byte, 8'h03, "R6 last busy cycle keeps old bits");
    @(negedge clk);
    chk(status_byte, 8'h8C, "R5 R6 R2 R3 commit at busy end");

    // hardware-protected mode: lock set first, then pin low
    wp_n = 1'b0;
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRSR, '0, 8'h00, 1'b1, 1'b0, 1'b0, "R4 WRSR in HPM");
    repeat (BUSY) @(negedge clk);
    chk(status_byte, 8'h8E, "R4 register unchanged, WEL kept");
    wp_n = 1'b1;
    issue(OP_WRSR, '0, 8'h75, 1'b1, 1'b1, 1'b0, "R4 WRSR with pin high");
    wait_idle();
    chk(status_byte, 8'h04, "R5 only b7 b3 b2 taken");

    // BP = 01 : upper quarter
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRITE, 19'h60000, 8'h11, 1'b1, 1'b0, 1'b0, "R1 quarter low edge");
    issue(OP_WRITE, 19'h5FFFF, 8'h11, 1'b1, 1'b1, 1'b1, "R1 just below quarter");
    wait_idle();
    chk(status_byte, 8'h04, "R2 WEL cleared after WRITE");
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRITE, 19'h7FFFF, 8'h22, 1'b1, 1'b0, 1'b0, "R1 quarter top");
    issue(OP_WRITE, 19'h00010, 8'h22, 1'b0, 1'b0, 1'b0, "R7 unaligned termination");
    chk(status_byte, 8'h06, "R2 rejects keep WEL");

    // BP = 10 : upper half
    issue(OP_WRSR, '0, 8'h08, 1'b1, 1'b1, 1'b0, "R5 set BP 10");
    wait_idle();
    chk(status_byte, 8'h08, "R5 BP 10 stored");
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRITE, 19'h40000, 8'h33, 1'b1, 1'b0, 1'b0, "R1 half low edge");
    issue(OP_WRITE, 19'h3FFFF, 8'h33, 1'b1, 1'b1, 1'b1, "R1 just below half");
    wait_idle();

    // BP = 11 : whole array
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRSR, '0, 8'h0C, 1'b1, 1'b1, 1'b0, "R5 set BP 11");
    wait_idle();
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    issue(OP_WRITE, 19'h00000, 8'h44, 1'b1, 1'b0, 1'b0, "R1 whole array");
    issue(OP_IDLOCK, 19'h00400, 8'h01, 1'b1, 1'b0, 1'b0, "R7 lock with BP 11");
    issue(OP_IDWR, 19'h00005, 8'h55, 1'b1, 1'b1, 1'b1, "R10 ID write prog");
    wait_idle();
    chk(status_byte, 8'h0C, "R2 WEL cleared after ID write");

    issue(OP_READ, 19'h00000, '0, 1'b1, 1'b1, 1'b0, "R8 READ idle");
    issue(OP_NONE, '0, '0, 1'b1, 1'b0, 1'b0, "R8 unused code");

    // reset keeps non-volatile bits
    issue(OP_WREN, '0, '0, 1'b1, 1'b1, 1'b0, "R2 WREN");
    chk(status_byte, 8'h0E, "R2 WEL before reset");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status_byte, 8'h0C, "R9 reset keeps BP, clears WEL");
    chk({7'd0, resp_valid}, 8'h00, "R9 response idle after reset");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule